// File: doc/BRIEF.md
# Clock-crossing DDR3 request bridge

This block sits between a processor bus running on its own fast clock and the native user port of an external DDR3 memory controller, which runs on a separate, unrelated clock. The processor keeps its own clock for all of its logic. Accesses to the DDR3 address window are packed into commands and cross into the controller domain through an asynchronous command FIFO. A small engine on the controller clock drains that FIFO, issues one single-beat read or write per command, and waits for each handshake. Read results travel back to the processor through a second asynchronous FIFO.

The processor side sees a stall flag. A read stalls until the returned word is waiting at the head of the return FIFO. A write stalls until the controller has taken both the command and the write data and the engine has gone back to idle. Because only one access is ever outstanding, results come back in request order and neither FIFO can overflow.

Top module: `xclk_mem_bridge`

## Requirements
- R1: Only bus addresses in [0x0004_0000, 0x1004_0000) select the block. For any other address `bus_stall` is 0 in the same cycle, and no command reaches the controller.
- R2: A write strobe in the window produces one controller command with `mc_cmd` = 3'b000. `mc_addr` is the byte offset (address minus 0x0004_0000, 28 bits). `mc_wr_data` is the bus data, and `mc_wr_mask` is the bitwise inverse of `bus_be` (mask bit 1 = byte not written; byte i is bits 8i+7..8i). `mc_wr_last` always equals `mc_wr_valid`.
- R3: During a write, `bus_stall` is 1 from the strobe cycle until the controller has accepted both the command and the data and the engine has returned to idle.
- R4: A read strobe in the window issues `mc_cmd` = 3'b001 at the same offset. `bus_stall` is 1 while the return FIFO is empty. In the first cycle it is 0, `bus_rdata` holds the returned word, and the word is removed at that clock edge.
- R5: Results come back in request order. A read returns the data of the most recent write to that line, with masked bytes keeping their old value. The return FIFO never receives a push while full.
- R6: The engine holds `mc_en`, `mc_addr` and `mc_cmd` until `mc_rdy` is seen high. It holds `mc_wr_valid` and `mc_wr_data` until `mc_wr_rdy` is seen high.
- R7: While `mc_calib_done` is 0, no command and no write data are presented; an access in the window stays stalled.
- R8: Each access in the window yields exactly one controller command. The command FIFO is never offered a new access while full.
- R9: After reset, `bus_stall`, `mc_en` and `mc_wr_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Processor bus clock |
| cpu_rst | input | 1 | Synchronous active-high reset, processor domain |
| bus_strobe | input | 1 | One-cycle pulse starting an access |
| bus_re | input | 1 | Read, held until the stall drops |
| bus_we | input | 1 | Write, held until the stall drops |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 128 | Write data |
| bus_be | input | 16 | Byte enables, 1 = write that byte |
| bus_stall | output | 1 | Processor must hold the access |
| bus_rdata | output | 128 | Read result, valid when a read is not stalled |
| mc_clk | input | 1 | Controller user clock |
| mc_rst | input | 1 | Synchronous active-high reset, controller domain |
| mc_calib_done | input | 1 | Controller initialization finished |
| mc_rdy | input | 1 | Controller accepts a command |
| mc_wr_rdy | input | 1 | Controller accepts write data |
| mc_rd_data | input | 128 | Returned read word |
| mc_rd_valid | input | 1 | Returned read word valid pulse |
| mc_en | output | 1 | Command valid |
| mc_cmd | output | 3 | Command code, 000 write, 001 read |
| mc_addr | output | 28 | Byte offset within the window |
| mc_wr_valid | output | 1 | Write data valid |
| mc_wr_last | output | 1 | Last beat of write data |
| mc_wr_data | output | 128 | Write data |
| mc_wr_mask | output | 16 | Byte mask, 1 = keep old byte |

## Verification
The stall rules take effect in the strobe cycle itself, so the bench samples `bus_stall` at the falling edge just before the strobe is clocked. It also checks every falling edge that an out-of-window access never stalls. The end of a write and the arrival of read data depend on random controller back-pressure, random read latency and two-flop crossings. For these results the bench waits for the falling edge where the stall first reads 0. There it compares the data against its shadow memory and the controller stub's command and write counters, all of which must already have moved by then. Handshake holding and calibration gating are checked on every controller-clock edge by the stub.

// File: rtl/xmb_pkg.sv
package xmb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE_WRITE,
    ST_ISSUE_READ,
    ST_WAIT_READ
  } eng_state_t;

  localparam logic [2:0] MC_CMD_WRITE = 3'b000;
  localparam logic [2:0] MC_CMD_READ  = 3'b001;
endpackage

// File: rtl/xmb_sync.sv
module xmb_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/xmb_afifo.sv
module xmb_afifo #(
  parameter int W  = 8,
  parameter int AW = 2
) (
  input  logic         wclk,
  input  logic         wrst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  output logic         full,
  input  logic         rclk,
  input  logic         rrst,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wbin, wgray, wbin_n;
  logic [AW:0]  rbin, rgray, rbin_n;
  logic [AW:0]  rgray_at_w, wgray_at_r;
  logic         wr_ok, rd_ok;

  // write side
  assign wr_ok  = push & ~full;
  assign wbin_n = wbin + {{AW{1'b0}}, wr_ok};

  always_ff @(posedge wclk) begin
    if (wr_ok) mem[wbin[AW-1:0]] <= wdata;
  end

  always_ff @(posedge wclk) begin
    if (wrst) begin
      wbin  <= '0;
      wgray <= '0;
    end else begin
      wbin  <= wbin_n;
      wgray <= wbin_n ^ (wbin_n >> 1);
    end
  end

  xmb_sync #(.W(AW + 1)) u_r2w (
    .clk(wclk), .rst(wrst), .d(rgray), .q(rgray_at_w)
  );

  assign full = (wgray == {~rgray_at_w[AW:AW-1], rgray_at_w[AW-2:0]});

  // read side
  assign rd_ok  = pop & ~empty;
  assign rbin_n = rbin + {{AW{1'b0}}, rd_ok};

  always_ff @(posedge rclk) begin
    if (rrst) begin
      rbin  <= '0;
      rgray <= '0;
    end else begin
      rbin  <= rbin_n;
      rgray <= rbin_n ^ (rbin_n >> 1);
    end
  end

  xmb_sync #(.W(AW + 1)) u_w2r (
    .clk(rclk), .rst(rrst), .d(wgray), .q(wgray_at_r)
  );

  assign empty = (rgray == wgray_at_r);
  assign rdata = mem[rbin[AW-1:0]];
endmodule

// File: rtl/xmb_engine.sv
module xmb_engine
  import xmb_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int MASK_W = 16,
  parameter int MC_AW  = 28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              calib,
  input  logic              cmd_avail,
  input  logic              cmd_is_wr,
  input  logic [MC_AW-1:0]  cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic [MASK_W-1:0] cmd_be,
  output logic              cmd_take,
  input  logic              mc_rdy,
  input  logic              mc_wr_rdy,
  input  logic              mc_rd_valid,
  input  logic [DATA_W-1:0] mc_rd_data,
  output logic              mc_en,
  output logic [2:0]        mc_cmd,
  output logic [MC_AW-1:0]  mc_addr,
  output logic              mc_wr_valid,
  output logic [DATA_W-1:0] mc_wr_data,
  output logic [MASK_W-1:0] mc_wr_mask,
  output logic              ret_push,
  output logic [DATA_W-1:0] ret_data,
  output logic              wr_done_tgl
);
  eng_state_t state;
  logic       cmd_clear, data_clear;

  assign cmd_take   = (state == ST_IDLE) & calib & cmd_avail;
  assign cmd_clear  = ~mc_en | mc_rdy;
  assign data_clear = ~mc_wr_valid | mc_wr_rdy;
  assign ret_push   = (state == ST_WAIT_READ) & mc_rd_valid;
  assign ret_data   = mc_rd_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      mc_en       <= 1'b0;
      mc_cmd      <= MC_CMD_READ;
      mc_addr     <= '0;
      mc_wr_valid <= 1'b0;
      mc_wr_data  <= '0;
      mc_wr_mask  <= '1;
      wr_done_tgl <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cmd_take) begin
            mc_en   <= 1'b1;
            mc_addr <= cmd_addr;
            if (cmd_is_wr) begin
              mc_cmd      <= MC_CMD_WRITE;
              mc_wr_valid <= 1'b1;
              mc_wr_data  <= cmd_data;
              mc_wr_mask  <= ~cmd_be;
              state       <= ST_ISSUE_WRITE;
            end else begin
              mc_cmd <= MC_CMD_READ;
              state  <= ST_ISSUE_READ;
            end
          end
        end
        ST_ISSUE_WRITE: begin
          if (mc_rdy)    mc_en       <= 1'b0;
          if (mc_wr_rdy) mc_wr_valid <= 1'b0;
          if (cmd_clear && data_clear) begin
            state       <= ST_IDLE;
            wr_done_tgl <= ~wr_done_tgl;
          end
        end
        ST_ISSUE_READ: begin
          if (mc_rdy) begin
            mc_en <= 1'b0;
            state <= ST_WAIT_READ;
          end
        end
        ST_WAIT_READ: begin
          if (mc_rd_valid) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xclk_mem_bridge.sv
module xclk_mem_bridge #(
  parameter int              BUS_AW   = 32,
  parameter int              DATA_W   = 128,
  parameter logic [31:0]     WIN_BASE = 32'h0004_0000,
  parameter int              WIN_BITS = 28,
  parameter int              FIFO_AW  = 2
) (
  input  logic                cpu_clk,
  input  logic                cpu_rst,
  input  logic                bus_strobe,
  input  logic                bus_re,
  input  logic                bus_we,
  input  logic [BUS_AW-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic [DATA_W/8-1:0] bus_be,
  output logic                bus_stall,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                mc_clk,
  input  logic                mc_rst,
  input  logic                mc_calib_done,
  input  logic                mc_rdy,
  input  logic                mc_wr_rdy,
  input  logic [DATA_W-1:0]   mc_rd_data,
  input  logic                mc_rd_valid,
  output logic                mc_en,
  output logic [2:0]          mc_cmd,
  output logic [WIN_BITS-1:0] mc_addr,
  output logic                mc_wr_valid,
  output logic                mc_wr_last,
  output logic [DATA_W-1:0]   mc_wr_data,
  output logic [DATA_W/8-1:0] mc_wr_mask
);
  localparam int MASK_W = DATA_W / 8;
  localparam int CMD_W  = 1 + WIN_BITS + DATA_W + MASK_W;
  localparam logic [BUS_AW:0] WIN_LO = {{(BUS_AW + 1 - 32){1'b0}}, WIN_BASE};
  localparam logic [BUS_AW:0] WIN_HI = WIN_LO + ((BUS_AW + 1)'(1) << WIN_BITS);

  // processor-domain decode
  logic                sel, is_wr, cmd_push, cmd_full;
  logic [BUS_AW:0]     addr_ext;
  logic [BUS_AW-1:0]   offset_full;
  logic [CMD_W-1:0]    cmd_in, cmd_out;
  logic                rvalid, ret_empty, ret_pop, ret_full;
  logic                wr_pend, done_sync, done_seen, done_edge;

  assign addr_ext    = {1'b0, bus_addr};
  assign sel         = (addr_ext >= WIN_LO) && (addr_ext < WIN_HI);
  assign offset_full = bus_addr - WIN_LO[BUS_AW-1:0];
  assign is_wr       = bus_we & ~bus_re;
  assign cmd_push    = bus_strobe & sel & (bus_re | bus_we) & ~cmd_full;
  assign cmd_in      = {is_wr, offset_full[WIN_BITS-1:0], bus_wdata, bus_be};

  assign rvalid    = ~ret_empty;
  assign ret_pop   = sel & bus_re & rvalid;
  assign bus_stall = sel & ((bus_re & ~rvalid) |
                            (~bus_re & (wr_pend | (bus_strobe & bus_we))));

  xmb_sync #(.W(1)) u_done_sync (
    .clk(cpu_clk), .rst(cpu_rst), .d(wr_done_tgl), .q(done_sync)
  );

  assign done_edge = done_sync ^ done_seen;

  always_ff @(posedge cpu_clk) begin
    if (cpu_rst) begin
      wr_pend   <= 1'b0;
      done_seen <= 1'b0;
    end else begin
      done_seen <= done_sync;
      if (done_edge)                wr_pend <= 1'b0;
      else if (cmd_push && is_wr)   wr_pend <= 1'b1;
    end
  end

  // crossings
  logic cmd_empty, cmd_take, ret_push, wr_done_tgl;
  logic [DATA_W-1:0] ret_data;

  xmb_afifo #(.W(CMD_W), .AW(FIFO_AW)) u_cmd_fifo (
    .wclk(cpu_clk), .wrst(cpu_rst), .push(cmd_push), .wdata(cmd_in), .full(cmd_full),
    .rclk(mc_clk), .rrst(mc_rst), .pop(cmd_take), .rdata(cmd_out), .empty(cmd_empty)
  );

  xmb_afifo #(.W(DATA_W), .AW(FIFO_AW)) u_ret_fifo (
    .wclk(mc_clk), .wrst(mc_rst), .push(ret_push), .wdata(ret_data), .full(ret_full),
    .rclk(cpu_clk), .rrst(cpu_rst), .pop(ret_pop), .rdata(bus_rdata), .empty(ret_empty)
  );

  // controller-domain engine
  xmb_engine #(.DATA_W(DATA_W), .MASK_W(MASK_W), .MC_AW(WIN_BITS)) u_engine (
    .clk        (mc_clk),
    .rst        (mc_rst),
    .calib      (mc_calib_done),
    .cmd_avail  (~cmd_empty),
    .cmd_is_wr  (cmd_out[CMD_W-1]),
    .cmd_addr   (cmd_out[CMD_W-2 -: WIN_BITS]),
    .cmd_data   (cmd_out[MASK_W +: DATA_W]),
    .cmd_be     (cmd_out[MASK_W-1:0]),
    .cmd_take   (cmd_take),
    .mc_rdy     (mc_rdy),
    .mc_wr_rdy  (mc_wr_rdy),
    .mc_rd_valid(mc_rd_valid),
    .mc_rd_data (mc_rd_data),
    .mc_en      (mc_en),
    .mc_cmd     (mc_cmd),
    .mc_addr    (mc_addr),
    .mc_wr_valid(mc_wr_valid),
    .mc_wr_data (mc_wr_data),
    .mc_wr_mask (mc_wr_mask),
    .ret_push   (ret_push),
    .ret_data   (ret_data),
    .wr_done_tgl(wr_done_tgl)
  );

  assign mc_wr_last = mc_wr_valid;
endmodule

// File: rtl/xmb_checks.sv
module xmb_checks #(
  parameter int MC_AW  = 28,
  parameter int DATA_W = 128
) (
  input logic              cpu_clk,
  input logic              cpu_rst,
  input logic              mc_clk,
  input logic              mc_rst,
  input logic              sel,
  input logic              bus_strobe,
  input logic              bus_re,
  input logic              bus_we,
  input logic              bus_stall,
  input logic              rvalid,
  input logic              cmd_full,
  input logic              ret_push,
  input logic              ret_full,
  input logic              calib,
  input logic              mc_en,
  input logic              mc_rdy,
  input logic [2:0]        mc_cmd,
  input logic [MC_AW-1:0]  mc_addr,
  input logic              mc_wr_valid,
  input logic              mc_wr_rdy,
  input logic [DATA_W-1:0] mc_wr_data
);
  p_outside_no_stall_r1: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
    !sel |-> !bus_stall);

  p_read_waits_r4: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
    (sel && bus_re && !rvalid) |-> bus_stall);

  p_no_overflow_r8: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
    (bus_strobe && sel && (bus_re || bus_we)) |-> !cmd_full);

  p_ret_no_overflow_r5: assert property (@(posedge mc_clk) disable iff (mc_rst)
    ret_push |-> !ret_full);

  p_cmd_hold_r6: assert property (@(posedge mc_clk) disable iff (mc_rst)
    (mc_en && !mc_rdy) |=> (mc_en && $stable(mc_addr) && $stable(mc_cmd)));

  p_data_hold_r6: assert property (@(posedge mc_clk) disable iff (mc_rst)
    (mc_wr_valid && !mc_wr_rdy) |=> (mc_wr_valid && $stable(mc_wr_data)));

  p_calib_gate_r7: assert property (@(posedge mc_clk) disable iff (mc_rst)
    !calib |-> (!mc_en && !mc_wr_valid));
endmodule

bind xclk_mem_bridge xmb_checks #(.MC_AW(WIN_BITS), .DATA_W(DATA_W)) u_checks (
  .cpu_clk    (cpu_clk),
  .cpu_rst    (cpu_rst),
  .mc_clk     (mc_clk),
  .mc_rst     (mc_rst),
  .sel        (sel),
  .bus_strobe (bus_strobe),
  .bus_re     (bus_re),
  .bus_we     (bus_we),
  .bus_stall  (bus_stall),
  .rvalid     (rvalid),
  .cmd_full   (cmd_full),
  .ret_push   (ret_push),
  .ret_full   (ret_full),
  .calib      (mc_calib_done),
  .mc_en      (mc_en),
  .mc_rdy     (mc_rdy),
  .mc_cmd     (mc_cmd),
  .mc_addr    (mc_addr),
  .mc_wr_valid(mc_wr_valid),
  .mc_wr_rdy  (mc_wr_rdy),
  .mc_wr_data (mc_wr_data)
);

// File: tb/xclk_mem_bridge_bench.sv
`timescale 1ns/1ps
module xclk_mem_bridge_bench;
  localparam logic [31:0] BASE = 32'h0004_0000;
  localparam logic [31:0] TOP  = 32'h1004_0000;

  logic cpu_clk = 0, mc_clk = 0;
  logic cpu_rst = 1, mc_rst = 1;
  always #2   cpu_clk = ~cpu_clk;   // 250 MHz
  always #3.1 mc_clk  = ~mc_clk;    // unrelated controller clock

  logic         bus_strobe = 0, bus_re = 0, bus_we = 0;
  logic [31:0]  bus_addr = 0;
  logic [127:0] bus_wdata = 0;
  logic [15:0]  bus_be = 0;
  logic         bus_stall;
  logic [127:0] bus_rdata;
  logic         calib = 0;
  logic         mc_rdy = 0, mc_wr_rdy = 0, mc_rd_valid = 0;
  logic [127:0] mc_rd_data = 0;
  logic         mc_en, mc_wr_valid, mc_wr_last;
  logic [2:0]   mc_cmd;
  logic [27:0]  mc_addr;
  logic [127:0] mc_wr_data;
  logic [15:0]  mc_wr_mask;

  xclk_mem_bridge u_xclk_mem_bridge (
    .cpu_clk(cpu_clk), .cpu_rst(cpu_rst), .bus_strobe(bus_strobe), .bus_re(bus_re),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .bus_stall(bus_stall), .bus_rdata(bus_rdata), .mc_clk(mc_clk), .mc_rst(mc_rst),
    .mc_calib_done(calib), .mc_rdy(mc_rdy), .mc_wr_rdy(mc_wr_rdy), .mc_rd_data(mc_rd_data),
    .mc_rd_valid(mc_rd_valid), .mc_en(mc_en), .mc_cmd(mc_cmd), .mc_addr(mc_addr),
    .mc_wr_valid(mc_wr_valid), .mc_wr_last(mc_wr_last), .mc_wr_data(mc_wr_data),
    .mc_wr_mask(mc_wr_mask)
  );

  int checks = 0, errors = 0, mc_checks = 0, mc_errors = 0;
  bit done = 0;

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- controller stub (controller clock) ----------------
  logic [127:0] smem [int];
  int           cmd_count = 0, wr_applied = 0, rd_lat = 0, rd_idx = 0;
  logic [27:0]  last_addr = 0;
  logic [2:0]   last_cmd = 3'b111;
  bit           have_cmd = 0, have_data = 0, prev_wait = 0, prev_dwait = 0;
  int           pend_idx = 0;
  logic [127:0] pend_data = 0, prev_wdata = 0;
  logic [15:0]  pend_mask = 0;
  logic [27:0]  prev_addr = 0;

  always @(posedge mc_clk) begin
    if (mc_rst) begin
      mc_rdy <= 0; mc_wr_rdy <= 0; mc_rd_valid <= 0;
    end else begin
      // R6: held until ready
      if (prev_wait) begin
        mc_checks++;
        if (!mc_en || mc_addr !== prev_addr) begin
          mc_errors++;
          $display("FAIL R6 cmd not held actual=%0b/%h expected=1/%h", mc_en, mc_addr, prev_addr);
        end
      end
      if (prev_dwait) begin
        mc_checks++;
        if (!mc_wr_valid || mc_wr_data !== prev_wdata) begin
          mc_errors++;
          $display("FAIL R6 data not held actual=%0b/%h expected=1/%h", mc_wr_valid, mc_wr_data, prev_wdata);
        end
      end
      // R7: nothing offered before calibration
      if (!calib) begin
        mc_checks++;
        if (mc_en || mc_wr_valid) begin
          mc_errors++;
          $display("FAIL R7 request before calib actual=%0b%0b expected=00", mc_en, mc_wr_valid);
        end
      end
      // R2: last strobe follows write valid
      if (mc_wr_valid || mc_wr_last) begin
        mc_checks++;
        if (mc_wr_last !== mc_wr_valid) begin
          mc_errors++;
          $display("FAIL R2 wr_last actual=%0b expected=%0b", mc_wr_last, mc_wr_valid);
        end
      end
      prev_wait  = mc_en && !mc_rdy;
      prev_addr  = mc_addr;
      prev_dwait = mc_wr_valid && !mc_wr_rdy;
      prev_wdata = mc_wr_data;

      mc_rd_valid <= 0;
      if (mc_en && mc_rdy) begin
        cmd_count++;
        last_addr = mc_addr;
        last_cmd  = mc_cmd;
        if (mc_cmd == 3'b001) begin
          rd_idx = int'(mc_addr >> 4);
          rd_lat = 1 + int'($urandom % 6);
        end else begin
          have_cmd = 1;
          pend_idx = int'(mc_addr >> 4);
        end
      end
      if (mc_wr_valid && mc_wr_rdy) begin
        have_data = 1;
        pend_data = mc_wr_data;
        pend_mask = mc_wr_mask;
      end
      if (have_cmd && have_data) begin
        logic [127:0] w;
        w = smem.exists(pend_idx) ? smem[pend_idx] : '0;
        for (int b = 0; b < 16; b++)
          if (!pend_mask[b]) w[8*b +: 8] = pend_data[8*b +: 8];
        smem[pend_idx] = w;
        wr_applied++;
        have_cmd = 0;
        have_data = 0;
      end
      if (rd_lat > 0) begin
        rd_lat--;
        if (rd_lat == 0) begin
          mc_rd_valid <= 1;
          mc_rd_data  <= smem.exists(rd_idx) ? smem[rd_idx] : '0;
        end
      end
      mc_rdy    <= ($urandom % 4) != 0;
      mc_wr_rdy <= ($urandom % 4) != 0;
    end
  end

  // ---------------- per-cycle check of the window rule ----------------
  always @(negedge cpu_clk) begin
    if (!cpu_rst && (bus_re || bus_we) && (bus_addr < BASE || bus_addr >= TOP))
      check("R1 stall outside window", 128'(bus_stall), 128'(0));
  end

  // ---------------- bench reference model ----------------
  logic [127:0] shadow [int];

  function automatic logic in_win(input logic [31:0] a);
    return (a >= BASE) && (a < TOP);
  endfunction

  task automatic do_write(input logic [31:0] a, input logic [127:0] d, input logic [15:0] be);
    int c0, w0, idx;
    logic [127:0] w;
    c0 = cmd_count; w0 = wr_applied;
    @(posedge cpu_clk); #1;
    bus_addr = a; bus_wdata = d; bus_be = be; bus_we = 1; bus_re = 0; bus_strobe = 1;
    @(negedge cpu_clk);
    if (in_win(a)) check("R3 stall in write strobe cycle", 128'(bus_stall), 128'(1));
    @(posedge cpu_clk); #1; bus_strobe = 0;
    do @(negedge cpu_clk); while (bus_stall);
    if (in_win(a)) begin
      check("R3 write landed before stall drop", 128'(wr_applied), 128'(w0 + 1));
      check("R8 one command per write", 128'(cmd_count), 128'(c0 + 1));
      check("R2 write code", 128'(last_cmd), 128'(3'b000));
      check("R2 write offset", 128'(last_addr), 128'(a - BASE));
      idx = int'((a - BASE) >> 4);
      w = shadow.exists(idx) ? shadow[idx] : '0;
      for (int b = 0; b < 16; b++) if (be[b]) w[8*b +: 8] = d[8*b +: 8];
      shadow[idx] = w;
    end
    @(posedge cpu_clk); #1; bus_we = 0;
  endtask

  task automatic do_read(input logic [31:0] a, input string req);
    int c0, idx;
    logic [127:0] exp;
    c0 = cmd_count;
    @(posedge cpu_clk); #1;
    bus_addr = a; bus_re = 1; bus_we = 0; bus_strobe = 1;
    @(negedge cpu_clk);
    if (in_win(a)) check("R4 stall in read strobe cycle", 128'(bus_stall), 128'(1));
    @(posedge cpu_clk); #1; bus_strobe = 0;
    do @(negedge cpu_clk); while (bus_stall);
    if (in_win(a)) begin
      idx = int'((a - BASE) >> 4);
      exp = shadow.exists(idx) ? shadow[idx] : '0;
      check(req, bus_rdata, exp);
      check("R4 read code", 128'(last_cmd), 128'(3'b001));
      check("R8 one command per read", 128'(cmd_count), 128'(c0 + 1));
    end
    @(posedge cpu_clk); #1; bus_re = 0;
  endtask

  initial begin
    repeat (8) @(posedge cpu_clk);
    @(negedge cpu_clk);
    check("R9 reset stall", 128'(bus_stall), 128'(0));
    #1; cpu_rst = 0; mc_rst = 0;
    repeat (4) @(negedge cpu_clk);
    check("R9 reset mc_en", 128'(mc_en), 128'(0));
    check("R9 reset wr_valid", 128'(mc_wr_valid), 128'(0));

    // R7: write held off until calibration finishes
    fork
      do_write(BASE + 32'h100, {4{32'hCAFE_0001}}, 16'hFFFF);
      begin
        repeat (40) @(negedge cpu_clk);
        check("R7 stalled before calib", 128'(bus_stall), 128'(1));
        check("R7 no command before calib", 128'(cmd_count), 128'(0));
        calib = 1;
      end
    join
    do_read(BASE + 32'h100, "R5 data after calib");

    // several full writes, then read back in a different order (R5)
    do_write(BASE,                  {4{32'h1111_2222}}, 16'hFFFF);
    do_write(BASE + 32'h10,         {4{32'h3333_4444}}, 16'hFFFF);
    do_write(TOP - 32'h10,          {4{32'h5555_6666}}, 16'hFFFF);
    do_read(TOP - 32'h10, "R5 top line");
    do_read(BASE,         "R5 first line");
    do_read(BASE + 32'h10, "R5 second line");

    // single-byte and mixed masks (R2, R5)
    do_write(BASE + 32'h40, {4{32'hA5A5_A5A5}}, 16'hFFFF);
    do_write(BASE + 32'h40, 128'h00FF, 16'h0001);
    do_read(BASE + 32'h40, "R5 single byte write");
    do_write(BASE + 32'h40, {4{32'h0F0F_0F0F}}, 16'hF00F);
    do_read(BASE + 32'h40, "R5 mixed mask");

    // outside the window (R1)
    begin
      int c0;
      c0 = cmd_count;
      do_read(BASE - 32'h10, "R1 below");
      do_write(TOP, {4{32'hDEAD_BEEF}}, 16'hFFFF);
      repeat (30) @(negedge cpu_clk);
      check("R1 no command outside window", 128'(cmd_count), 128'(c0));
      do_read(TOP - 32'h10, "R1 top line untouched");
    end

    // random traffic (R5, R6)
    for (int i = 0; i < 20; i++) begin
      logic [31:0] a;
      a = BASE + (($urandom % 64) << 4);
      do_write(a, {$urandom, $urandom, $urandom, $urandom}, 16'($urandom));
      do_read(BASE + (($urandom % 64) << 4), "R5 random read");
      do_read(a, "R5 read after write");
    end

    repeat (10) @(posedge cpu_clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors + mc_errors, checks + mc_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge cpu_clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors + mc_errors, checks + mc_checks);
      $finish;
    end
  end
endmodule